// File: doc/BRIEF.md
# ROM Integrity Check Sequencer

After reset, this block checks the contents of a ROM once. It reads the ROM from address zero and sends every data word to an external hash engine over a valid/ready channel. The final data word carries a last flag. The top `DIG_WORDS` words of the ROM are not sent to the hash engine. They hold the expected digest, and the block loads them into a register while the engine is still working.

The hash engine answers with one completion pulse that carries the computed digest. The block then compares the computed digest with the expected one in a single cycle. It tells the power manager that the check has finished and whether it passed, using 4-bit multi-bit booleans. In the same cycle it presents the computed digest, marked valid, to the key manager. After that, every output stays fixed until the next reset. The block ignores any later response from the engine.

Top module: `rom_check_seq`

## Requirements
- R1: While reset is asserted, `pm_done_o` and `pm_good_o` both hold the false code 4'b1001, `hash_valid_o` and `km_valid_o` are 0, and `rom_addr_o` is 0.
- R2: The data words at addresses 0 to ROM_WORDS-DIG_WORDS-1 go to the hash engine in ascending order, one per handshake (`hash_valid_o` and `hash_ready_i` both high). While a request is stalled, valid stays high and the data stays unchanged.
- R3: `hash_last_o` is high on the handshake of the word at address ROM_WORDS-DIG_WORDS-1 and on no other handshake.
- R4: Once the completion pulse has been received, `hash_valid_o` stays low on every cycle until reset.
- R5: `pm_done_o` keeps the false code until the completion pulse has been received.
- R6: The expected digest is built from the top ROM words, with word i taken from address ROM_WORDS-DIG_WORDS+i and placed in bits [i*DW +: DW]. When it equals the returned digest, `pm_good_o` is the true code 4'b0110 when `pm_done_o` becomes true (4'b0110).
- R7: When the returned digest differs from the expected digest in any bit, `pm_good_o` is the false code 4'b1001 when `pm_done_o` becomes true.
- R8: Once `pm_done_o` is true, `pm_done_o` and `pm_good_o` keep their values on every later cycle until reset.
- R9: `km_valid_o` is high exactly on the cycles where `pm_done_o` is true. While it is high, `km_digest_o` equals the digest carried by the first completion pulse.
- R10: Only the first completion pulse after reset is used. A later pulse with a different digest changes neither the power-manager outputs nor the key-manager outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rom_addr_o | output | AW | ROM word address |
| rom_rdata_i | input | DW | ROM word at `rom_addr_o`, valid in the same cycle |
| hash_valid_o | output | 1 | Request valid toward the hash engine |
| hash_ready_i | input | 1 | Hash engine accepts the current word |
| hash_data_o | output | DW | Word sent to the hash engine |
| hash_last_o | output | 1 | Marks the final data word |
| hash_done_i | input | 1 | Completion pulse from the hash engine |
| hash_digest_i | input | DW*DIG_WORDS | Digest carried by the completion pulse |
| pm_done_o | output | 4 | Check finished (multi-bit boolean) |
| pm_good_o | output | 4 | Check passed (multi-bit boolean) |
| km_valid_o | output | 1 | Digest for the key manager is valid |
| km_digest_o | output | DW*DIG_WORDS | Computed digest for the key manager |

## Verification
The assertions rely on three properties of the inputs:
- The ROM read is combinational, so `rom_rdata_i` already matches the address presented in the same cycle.
- The hash engine raises its completion pulse only after it has accepted the last-flagged word.
- `hash_ready_i` and `hash_done_i` change only between clock edges.

The bench meets these conditions by driving inputs only at the falling edge. It sends the first response a fixed number of cycles after the last handshake, with delays chosen so that some responses land before the expected digest has been fully read and some after. A second, deliberately wrong pulse is sent only after completion, to exercise R10.

// File: rtl/rom_check_seq.sv
module rom_check_seq #(
  parameter int DW        = 32,
  parameter int ROM_WORDS = 16,
  parameter int DIG_WORDS = 2,
  localparam int AW       = $clog2(ROM_WORDS),
  localparam int DGW      = DW * DIG_WORDS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [AW-1:0]  rom_addr_o,
  input  logic [DW-1:0]  rom_rdata_i,
  output logic           hash_valid_o,
  input  logic           hash_ready_i,
  output logic [DW-1:0]  hash_data_o,
  output logic           hash_last_o,
  input  logic           hash_done_i,
  input  logic [DGW-1:0] hash_digest_i,
  output logic [3:0]     pm_done_o,
  output logic [3:0]     pm_good_o,
  output logic           km_valid_o,
  output logic [DGW-1:0] km_digest_o
);

  localparam int DATA_WORDS = ROM_WORDS - DIG_WORDS;
  localparam logic [3:0] MB_TRUE  = 4'b0110;
  localparam logic [3:0] MB_FALSE = 4'b1001;
  localparam logic [AW-1:0] LAST_DATA = AW'(DATA_WORDS - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(ROM_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_CMP, S_DONE} state_t;

  state_t state;
  logic [AW-1:0] addr;
  logic          exp_done;
  logic          rsp_seen;
  logic [DGW-1:0] dig_q;
  logic [DIG_WORDS-1:0][DW-1:0] exp_q;

  wire hs       = hash_valid_o && hash_ready_i;
  wire exp_load = (state == S_WAIT) && !exp_done;

  assign rom_addr_o   = addr;
  assign hash_valid_o = (state == S_READ);
  assign hash_data_o  = rom_rdata_i;
  assign hash_last_o  = hash_valid_o && (addr == LAST_DATA);
  assign km_digest_o  = dig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      addr     <= '0;
      exp_done <= 1'b0;
    end else begin
      case (state)
        S_IDLE: state <= S_READ;
        S_READ: if (hs) begin
          addr <= addr + 1'b1;
          if (hash_last_o) state <= S_WAIT;
        end
        S_WAIT: begin
          if (!exp_done) begin
            if (addr == LAST_ADDR) exp_done <= 1'b1;
            else addr <= addr + 1'b1;
          end
          if (exp_done && rsp_seen) state <= S_CMP;
        end
        S_CMP:   state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end

  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_exp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) exp_q[g] <= '0;
      else if (exp_load && addr == AW'(DATA_WORDS + g)) exp_q[g] <= rom_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_seen <= 1'b0;
      dig_q    <= '0;
    end else if (hash_done_i && !rsp_seen) begin
      rsp_seen <= 1'b1;
      dig_q    <= hash_digest_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_done_o  <= MB_FALSE;
      pm_good_o  <= MB_FALSE;
      km_valid_o <= 1'b0;
    end else if (state == S_CMP) begin
      pm_done_o  <= MB_TRUE;
      pm_good_o  <= (dig_q == exp_q) ? MB_TRUE : MB_FALSE;
      km_valid_o <= 1'b1;
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o && !hash_ready_i |=> hash_valid_o && $stable(rom_addr_o));

  // R3
  last_ends_stream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o && hash_ready_i && hash_last_o |=> !hash_valid_o);

  // R4
  no_req_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_seen |-> !hash_valid_o);

  // R5
  done_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_done_o != MB_FALSE |-> rsp_seen);

  // R8
  pm_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_done_o == MB_TRUE |=> $stable(pm_done_o) && $stable(pm_good_o));

  // R9
  km_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    km_valid_o |-> pm_done_o == MB_TRUE);

  // R10
  digest_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_seen |=> $stable(km_digest_o));

endmodule

// File: tb/tb_rom_check_seq.sv
`timescale 1ns/1ps
module tb_rom_check_seq;
  localparam int DW = 32, RW = 16, DG = 2, AW = 4, DGW = DW * DG, NDATA = RW - DG;
  localparam logic [3:0] T = 4'b0110, F = 4'b1001;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_rdata, hash_data;
  logic hash_valid, hash_ready = 0, hash_last, hash_done = 0, km_valid;
  logic [DGW-1:0] hash_digest = '0, km_digest;
  logic [3:0] pm_done, pm_good;
  logic [DW-1:0] rom [RW];
  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign rom_rdata = rom[rom_addr];

  rom_check_seq #(.DW(DW), .ROM_WORDS(RW), .DIG_WORDS(DG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .hash_valid_o(hash_valid), .hash_ready_i(hash_ready), .hash_data_o(hash_data),
    .hash_last_o(hash_last), .hash_done_i(hash_done), .hash_digest_i(hash_digest),
    .pm_done_o(pm_done), .pm_good_o(pm_good), .km_valid_o(km_valid), .km_digest_o(km_digest));

  task automatic chk(bit ok, string req, logic [DGW-1:0] act, logic [DGW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rotl(logic [DW-1:0] x, int n);
    int r = (n % 31) + 1;
    return (x << r) | (x >> (DW - r));
  endfunction

  task automatic run(int pat, int dly, int bad);
    int n = 0, cnt = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e9 = 0, e8 = 0;
    bit pend = 0, given = 0, consumed = 0, prev_stall = 0, done_seen = 0;
    logic [DW-1:0] prev_data = '0, sum = '0, xr = '0, es = '0, ex = '0;
    logic [DGW-1:0] rdig = '0, edig;
    logic [3:0] sd, sg;
    logic [DGW-1:0] skd;
    for (int i = 0; i < NDATA; i++) begin
      rom[i] = (i * 32'h9E3779B9) ^ DW'((pat << 8) ^ (dly << 4) ^ bad);
      es = es + rom[i];
      ex = ex ^ rotl(rom[i], i);
    end
    edig = {ex, es};
    if (bad != 0) edig = edig ^ (64'h1 << ((pat * 13 + dly * 7) % 64));
    rom[NDATA] = edig[31:0];
    rom[NDATA+1] = edig[63:32];

    rst_n = 0; hash_ready = 0; hash_done = 0; hash_digest = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(pm_done == F && pm_good == F && !hash_valid && !km_valid && rom_addr == 0,
        "R1", {pm_done, pm_good, 3'b0, hash_valid, 3'b0, km_valid, 4'(rom_addr)},
        {F, F, 16'h0});
    rst_n = 1;

    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      if (given) consumed = 1;
      hash_done = 0;
      if (pend) begin
        if (cnt == 0) begin hash_done = 1; hash_digest = rdig; pend = 0; given = 1; end
        else cnt--;
      end
      hash_ready = (pat == 0) ? 1'b1 : (((cyc * 5 + pat) % 4) != 0);
      #1;
      if (consumed && hash_valid) e4++;
      if (pm_done != F && !consumed) e5++;
      if (km_valid != (pm_done == T)) e9++;
      if (prev_stall && (!hash_valid || hash_data != prev_data)) e2++;
      if (hash_valid && hash_ready) begin
        if (n >= NDATA || hash_data != rom[n]) e2++;
        if (hash_last != (n == NDATA - 1)) e3++;
        sum = sum + hash_data;
        xr = xr ^ rotl(hash_data, n);
        if (hash_last) begin pend = 1; cnt = dly; rdig = {xr, sum}; end
        n++;
      end
      prev_stall = hash_valid && !hash_ready;
      prev_data = hash_data;
      if (pm_done == T) begin done_seen = 1; break; end
    end

    chk(e2 == 0 && n == NDATA, "R2", DGW'(e2), DGW'(0));
    chk(e3 == 0, "R3", DGW'(e3), 0);
    chk(e4 == 0, "R4", DGW'(e4), 0);
    chk(e5 == 0 && done_seen, "R5", DGW'(e5), 0);
    if (bad != 0) chk(pm_good == F, "R7", DGW'(pm_good), DGW'(F));
    else          chk(pm_good == T, "R6", DGW'(pm_good), DGW'(T));
    chk(e9 == 0 && km_valid && km_digest == {ex, es}, "R9", km_digest, {ex, es});

    sd = pm_done; sg = pm_good; skd = km_digest;
    @(negedge clk);
    hash_done = 1; hash_digest = ~rdig;
    @(negedge clk);
    hash_done = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pm_done != sd || pm_good != sg || hash_valid) e8++;
    end
    chk(e8 == 0, "R8", DGW'({pm_done, pm_good}), DGW'({sd, sg}));
    chk(km_digest == skd && km_valid, "R10", km_digest, skd);
  endtask

  initial begin
    for (int p = 0; p < 4; p++)
      for (int d = 0; d < 6; d += 2)
        for (int b = 0; b < 2; b++)
          run(p, d, b);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end
endmodule